// File: doc/BRIEF.md
# Windowed Outbound Address Translator

The translator maps each 32-bit outbound CPU address onto one of two targets. The top four address bits are dropped. Bit 27 then picks the target. With bit 27 low, the request falls in a 128 MB aperture that belongs to the peripheral bus. Bits 26:24 choose one of eight 16 MB windows. The offset of the chosen window, a full 32-bit value held in a programmable register, is added to the low 24 bits of the address. With bit 27 high, the request goes to the memory target with bits 31:28 cleared and no offset added.

A small register port writes and reads the eight offsets. Offset n sits at byte offset 4·n. After reset every window holds the identity value 0x10000000 + n·0x01000000. Both outputs are registered, so each result appears one cycle after the request, and each output valid follows the request valid.

Top module: `xlate_top`

## Requirements
- R1: After reset, both output valids are 0, and window n holds 0x10000000 + n·0x01000000 (readable at register byte offset 4·n).
- R2: A request with addr[27]=0 raises periValid one cycle later with memValid low. A request with addr[27]=1 raises memValid one cycle later with periValid low. With reqValid low, neither output valid is raised.
- R3: The peripheral address is window[addr[26:24]] + addr[23:0], modulo 2^32, with no overflow flag. Bits 31:28 of the input have no effect.
- R4: The memory address is the input address with bits 31:28 cleared. No offset is applied.
- R5: A register write (regWe=1, regAddr[4:2] selects the window) changes the offset used by any request presented on a later cycle. A read returns the offset combinationally on regRdata.
- R6: The example translations hold at identity reset: input 0x100000ff gives 0x100000ff, and input 0x120000ff gives 0x120000ff.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request valid |
| reqAddr | input | 32 | CPU address |
| regWe | input | 1 | Offset register write enable |
| regAddr | input | 5 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data |
| periValid | output | 1 | Peripheral-side request valid |
| periAddr | output | 32 | Translated peripheral address |
| memValid | output | 1 | Memory-side request valid |
| memAddr | output | 32 | Memory-side address |

## Verification
A corrupted offset register appears on periAddr one cycle after any request that selects that window. The register read port also exposes it right away. A wrong route decode sets the wrong valid on the very next cycle. The bench sweeps all eight windows with several in-window offsets, covers both routes and high-nibble garbage, and tests offsets that force the 32-bit sum to wrap.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int ADDR_W = 32;
  localparam int NUM_WIN = 8;
  localparam int WIN_IDX_W = $clog2(NUM_WIN);
  localparam int SEG_W = 24;
  localparam logic [ADDR_W-1:0] ID_BASE = 32'h1000_0000;

  typedef struct packed {
    logic                 wrEn;
    logic [WIN_IDX_W-1:0] wrIdx;
    logic                 toPeri;
    logic                 toMem;
    logic [WIN_IDX_W-1:0] winSel;
  } xlateCtl_t;
endpackage

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              regWe,
  input  logic [4:0]        regAddr,
  output xlateCtl_t         ctl,
  output logic              periValid,
  output logic              memValid
);
  logic routeBit;
  assign routeBit = reqAddr[SEG_W+WIN_IDX_W];

  always_comb begin
    ctl.wrEn   = regWe;
    ctl.wrIdx  = regAddr[2+:WIN_IDX_W];
    ctl.toPeri = reqValid && !routeBit;
    ctl.toMem  = reqValid && routeBit;
    ctl.winSel = reqAddr[SEG_W+:WIN_IDX_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periValid <= 1'b0;
      memValid  <= 1'b0;
    end else begin
      periValid <= ctl.toPeri;
      memValid  <= ctl.toMem;
    end
  end

  a_r2_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(periValid && memValid));
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    (periValid || memValid) |-> $past(reqValid));
endmodule

// File: rtl/xlate_dp.sv
module xlate_dp
  import xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  xlateCtl_t         ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [4:0]        regAddr,
  input  logic [ADDR_W-1:0] regWdata,
  output logic [ADDR_W-1:0] regRdata,
  output logic [ADDR_W-1:0] periAddr,
  output logic [ADDR_W-1:0] memAddr
);
  logic [ADDR_W-1:0] winOff [NUM_WIN];
  logic [ADDR_W-1:0] segOff;
  logic [ADDR_W-1:0] sum;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) winOff[g] <= ID_BASE + (ADDR_W'(g) << SEG_W);
      else if (ctl.wrEn && ctl.wrIdx == WIN_IDX_W'(g)) winOff[g] <= regWdata;
    end
  end

  assign regRdata = winOff[regAddr[2+:WIN_IDX_W]];
  assign segOff   = {{(ADDR_W-SEG_W){1'b0}}, reqAddr[SEG_W-1:0]};
  assign sum      = winOff[ctl.winSel] + segOff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periAddr <= '0;
      memAddr  <= '0;
    end else begin
      if (ctl.toPeri) periAddr <= sum;
      if (ctl.toMem)  memAddr  <= {4'b0, reqAddr[ADDR_W-5:0]};
    end
  end

  a_r4_mem_top_clear: assert property (@(posedge clk) disable iff (!rstN)
    memAddr[ADDR_W-1:ADDR_W-4] == 4'b0);
  a_r3_low_bits: assert property (@(posedge clk) disable iff (!rstN)
    ctl.toPeri |=> periAddr[SEG_W-1:0] ==
      ($past(winOff[ctl.winSel][SEG_W-1:0]) + $past(reqAddr[SEG_W-1:0])));
endmodule

// File: rtl/xlate_top.sv
module xlate_top
  import xlate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [31:0] reqAddr,
  input  logic        regWe,
  input  logic [4:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        periValid,
  output logic [31:0] periAddr,
  output logic        memValid,
  output logic [31:0] memAddr
);
  xlateCtl_t ctl;

  xlate_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .regWe(regWe), .regAddr(regAddr), .ctl(ctl),
    .periValid(periValid), .memValid(memValid)
  );

  xlate_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .periAddr(periAddr), .memAddr(memAddr)
  );
endmodule

// File: tb/xlate_top_tb.sv
module xlate_top_tb;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rstN = 0;
  logic reqValid = 0, regWe = 0;
  logic [31:0] reqAddr = 0, regWdata = 0;
  logic [4:0] regAddr = 0;
  logic [31:0] regRdata, periAddr, memAddr;
  logic periValid, memValid;
  int total = 0, bad = 0;
  logic [31:0] model [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  xlate_top u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int idx, logic [31:0] d);
    @(negedge clk); regWe = 1; regAddr = 5'(idx*4); regWdata = d;
    @(negedge clk); regWe = 0;
    model[idx] = d;
  endtask

  task automatic send(logic [31:0] a);
    @(negedge clk); reqValid = 1; reqAddr = a;
    @(negedge clk); reqValid = 0;
    if (a[27] == 1'b0) begin
      chk("R2 periValid", 32'(periValid), 1); chk("R2 memValid", 32'(memValid), 0);
      chk("R3 periAddr", periAddr, model[a[26:24]] + {8'h0, a[23:0]});
    end else begin
      chk("R2 memValid", 32'(memValid), 1); chk("R2 periValid", 32'(periValid), 0);
      chk("R4 memAddr", memAddr, {4'h0, a[27:0]});
    end
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 32'h1000_0000 + 32'(i) * 32'h0100_0000;
    #(CLK_PERIOD*2); @(negedge clk); rstN = 1;
    @(negedge clk);
    chk("R1 periValid", 32'(periValid), 0);
    chk("R1 memValid", 32'(memValid), 0);
    for (int i = 0; i < 8; i++) begin
      regAddr = 5'(i*4); #1;
      chk("R1 reset offset", regRdata, model[i]);
    end
    // R6 examples
    send(32'h1000_00ff); chk("R6 ex0", periAddr, 32'h1000_00ff);
    send(32'h1200_00ff); chk("R6 ex2", periAddr, 32'h1200_00ff);
    // R2: idle yields no valid
    @(negedge clk); chk("R2 idle peri", 32'(periValid), 0); chk("R2 idle mem", 32'(memValid), 0);
    // sweep windows, top nibbles, offsets
    for (int w = 0; w < 8; w++)
      for (int t = 0; t < 4; t++) begin
        logic [31:0] a;
        a = {4'(t*5), 1'b0, 3'(w), 24'h00_0000 ^ (24'(t) * 24'h3F_FFFF)};
        send(a);
        send(a | 32'h0800_0000);
      end
    // R5: reprogram, including wrap
    wr(3, 32'hFFFF_FF00);
    regAddr = 5'd12; #1; chk("R5 readback", regRdata, 32'hFFFF_FF00);
    send(32'h0300_0100);
    chk("R3 wrap", periAddr, 32'h0000_0000);
    wr(7, 32'h0);
    wr(0, 32'hA5A5_0000);
    for (int w = 0; w < 8; w++) send({4'hF, 1'b0, 3'(w), 24'hFF_FFFF});
    // R5: write same cycle as request uses old value, next cycle new
    @(negedge clk); regWe = 1; regAddr = 5'd4; regWdata = 32'h4000_0000;
    reqValid = 1; reqAddr = 32'h0100_0010;
    @(negedge clk); regWe = 0;
    chk("R5 old offset same cycle", periAddr, model[1] + 32'h10);
    model[1] = 32'h4000_0000;
    reqAddr = 32'h0100_0010;
    @(negedge clk); reqValid = 0;
    chk("R5 new offset next cycle", periAddr, 32'h4000_0010);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule